// File: doc/BRIEF.md
# Reassembly Engine Run Controller

This block decides when a cell reassembly engine may take in new cells. Software reaches it through one 32-bit control word. The top bit enables the engine. The next bit holds the engine in hardware reset. The bit below that is reserved and always reads as zero. Two status bits at the bottom of the word report the engine's condition.

The processing pipeline marks the first and last cycle of each cell with start and end strobes. The controller grants a run permit, and only a start strobe seen while the permit is high opens a cell. A cell that has begun always runs to its end strobe. So clearing the enable bit stops the engine only between cells. Until that cell ends, the status reports a pending suspend.

The enable bit is cleared by any of these:
- the asynchronous system reset;
- a global clear input;
- a parity error that arrives while halt-on-parity is selected.

After any of these, software must write the enable bit again to resume.

Top module: `rsm_run_ctl`

## Requirements
- R1: After the system reset is released, the control word reads all zeros. The run permit and the engine reset output are low, and the status is 00 (halted).
- R2: A write with bit 31 set and bit 30 clear raises the run permit from the next cycle on, and the status becomes 01 (running).
- R3: A write that clears bit 31 drops the run permit from the next cycle. If a cell is open, the status is 10 (suspend pending) until the cycle after its end strobe, and then becomes 00.
- R4: Writing bit 31 set again after a suspend restores the run permit and status 01.
- R5: Bit 29 of the control word reads as zero whatever value is written to it.
- R6: The global clear input clears bits 31 and 30 and closes any open cell, on the next cycle.
- R7: A parity error while halt-on-parity is high clears bit 31 on the next cycle. A parity error while halt-on-parity is low changes nothing.
- R8: When a write of bit 31 set and a halting parity error fall in the same cycle, bit 31 ends up cleared.
- R9: While bit 30 is set, the engine reset output is high, the run permit is low, the status is 11, and any open cell is discarded.
- R10: The control word reads back bit 31 as enable, bit 30 as reset, bits 1:0 as status, and every other bit as zero.
- R11: A start strobe while the run permit is low opens no cell. A cycle carrying both strobes is a complete one-cycle cell, and the end strobe takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| glb_clr | input | 1 | Global clear of the control bits |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback with status |
| halt_on_par | input | 1 | Selects halt on parity error |
| par_err | input | 1 | Parity error pulse from the datapath |
| cell_sop | input | 1 | First cycle of a cell |
| cell_eop | input | 1 | Last cycle of a cell |
| run_ok | output | 1 | Permit to start a new cell |
| eng_rst | output | 1 | Hardware reset to the engine |
| run_state | output | 2 | 00 halted, 01 running, 10 suspend pending, 11 in reset |

## Verification
Every output comes straight from registers updated at the rising edge, so the effect of a write, a clear, a parity error or a cell strobe becomes visible exactly one cycle after the edge that samples it. The bench drives all inputs at the falling edge. It advances its reference model once per rising edge and compares every output at the following falling edge, which is the single cycle in which each result is due. Strobes are removed after each compare, so every check sees the consequence of exactly one cycle of stimulus.

// File: rtl/rsm_run_ctl.sv
module rsm_run_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        glb_clr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        halt_on_par,
  input  logic        par_err,
  input  logic        cell_sop,
  input  logic        cell_eop,
  output logic        run_ok,
  output logic        eng_rst,
  output logic [1:0]  run_state
);
  localparam int EN_BIT  = 31;
  localparam int RST_BIT = 30;
  localparam logic [1:0] ST_HALT = 2'b00;
  localparam logic [1:0] ST_RUN  = 2'b01;
  localparam logic [1:0] ST_PEND = 2'b10;
  localparam logic [1:0] ST_RST  = 2'b11;

  logic en_q, srst_q, cell_q;
  logic err_halt;

  assign err_halt = par_err & halt_on_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
    end else if (glb_clr) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      if (err_halt)    en_q <= 1'b0;
      else if (reg_wr) en_q <= reg_wdata[EN_BIT];
      if (reg_wr)      srst_q <= reg_wdata[RST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cell_q <= 1'b0;
    else if (glb_clr || srst_q)   cell_q <= 1'b0;
    else if (cell_eop)            cell_q <= 1'b0;
    else if (cell_sop && run_ok)  cell_q <= 1'b1;
  end

  assign run_ok    = en_q & ~srst_q;
  assign eng_rst   = srst_q;
  assign run_state = srst_q ? ST_RST  :
                     en_q   ? ST_RUN  :
                     cell_q ? ST_PEND : ST_HALT;
  assign reg_rdata = {en_q, srst_q, 28'd0, run_state};
endmodule

// File: rtl/rsm_run_ctl_chk.sv
module rsm_run_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        glb_clr,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        halt_on_par,
  input logic        par_err,
  input logic        cell_sop,
  input logic        cell_eop,
  input logic        run_ok,
  input logic        eng_rst,
  input logic [1:0]  run_state
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[29] == 1'b0); // R5
  AST_PAR_HALT: assert property (@(posedge clk) disable iff (!rst_n) (par_err && halt_on_par) |=> !reg_rdata[31]); // R7
  AST_GLB_CLR: assert property (@(posedge clk) disable iff (!rst_n) glb_clr |=> reg_rdata[31:30] == 2'b00); // R6
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) eng_rst |-> (!run_ok && run_state == 2'b11)); // R9
  AST_PEND_GATE: assert property (@(posedge clk) disable iff (!rst_n) run_state == 2'b10 |-> !run_ok); // R3
  AST_WR_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[31] && !reg_wdata[30] && !glb_clr && !(par_err && halt_on_par)) |=> run_ok); // R2
  AST_CELL_END: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'b10 && cell_eop && !reg_wr) |=> run_state == 2'b00); // R3
endmodule

bind rsm_run_ctl rsm_run_ctl_chk u_chk (.*);

// File: tb/tb_rsm_run_ctl.sv
`timescale 1ns/1ps
module tb_rsm_run_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic glb_clr = 0, reg_wr = 0, halt_on_par = 0, par_err = 0, cell_sop = 0, cell_eop = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic run_ok, eng_rst;
  logic [1:0] run_state;
  int n_chk = 0, n_fail = 0;
  bit m_en = 0, m_rst = 0, m_cell = 0;

  always #4 clk = ~clk;

  rsm_run_ctl dut (.*);

  function automatic logic [1:0] exp_state();
    return m_rst ? 2'b11 : m_en ? 2'b01 : m_cell ? 2'b10 : 2'b00;
  endfunction
  function automatic logic [31:0] exp_word();
    return {m_en, m_rst, 28'd0, exp_state()};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, reg_rdata, exp_word());
    chk(tag, {31'd0, run_ok}, {31'd0, m_en & ~m_rst});
    chk(tag, {31'd0, eng_rst}, {31'd0, m_rst});
    chk(tag, {30'd0, run_state}, {30'd0, exp_state()});
  endtask

  task automatic cyc(string tag);
    bit ok_now = m_en & ~m_rst;
    bit n_en = m_en, n_rst = m_rst, n_cell = m_cell;
    if (glb_clr) begin n_en = 0; n_rst = 0; end
    else begin
      if (par_err && halt_on_par) n_en = 0;
      else if (reg_wr) n_en = reg_wdata[31];
      if (reg_wr) n_rst = reg_wdata[30];
    end
    if (glb_clr || m_rst) n_cell = 0;
    else if (cell_eop) n_cell = 0;
    else if (cell_sop && ok_now) n_cell = 1;
    m_en = n_en; m_rst = n_rst; m_cell = n_cell;
    @(negedge clk);
    compare(tag);
    reg_wr = 0; glb_clr = 0; par_err = 0; cell_sop = 0; cell_eop = 0;
  endtask

  task automatic wr(logic [31:0] d, string tag);
    reg_wr = 1; reg_wdata = d; cyc(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    cell_sop = 1; cyc("R11");
    wr(32'hFFFF_FFFF & ~32'h4000_0000, "R5");
    chk("R5", {31'd0, reg_rdata[29]}, 32'd0);
    wr(32'h0000_0000, "R10");
    wr(32'h8000_0000, "R2");
    cell_sop = 1; cyc("R2");
    wr(32'h0000_0000, "R3");
    chk("R3", {30'd0, run_state}, 32'd2);
    cyc("R3");
    cell_eop = 1; cyc("R3");
    chk("R3", {30'd0, run_state}, 32'd0);
    wr(32'h8000_0000, "R4");
    chk("R4", {31'd0, run_ok}, 32'd1);
    cell_sop = 1; cell_eop = 1; cyc("R11");
    chk("R11", {30'd0, run_state}, 32'd1);
    halt_on_par = 0; par_err = 1; cyc("R7");
    chk("R7", {31'd0, run_ok}, 32'd1);
    halt_on_par = 1; par_err = 1; cyc("R7");
    chk("R7", {31'd0, reg_rdata[31]}, 32'd0);
    par_err = 1; wr(32'h8000_0000, "R8");
    chk("R8", {31'd0, reg_rdata[31]}, 32'd0);
    wr(32'h8000_0000, "R4");
    cell_sop = 1; cyc("R9");
    wr(32'hC000_0000, "R9");
    chk("R9", {31'd0, eng_rst}, 32'd1);
    cyc("R9");
    wr(32'h0000_0000, "R9");
    chk("R9", {30'd0, run_state}, 32'd0);
    wr(32'hC000_0000, "R6");
    glb_clr = 1; cyc("R6");
    chk("R6", reg_rdata, 32'd0);
    for (int i = 0; i < 4000; i++) begin
      if ((i % 256) == 0) halt_on_par = $urandom_range(0, 1);
      reg_wr = ($urandom_range(0, 7) == 0);
      reg_wdata = $urandom();
      reg_wdata[30] = ($urandom_range(0, 7) == 0);
      glb_clr = ($urandom_range(0, 63) == 0);
      par_err = ($urandom_range(0, 15) == 0);
      cell_sop = ($urandom_range(0, 3) == 0);
      cell_eop = ($urandom_range(0, 3) == 0);
      cyc("R10");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule